// File: doc/BRIEF.md
# Indexed Multiply-Add Group Sequencer

This block steps one multiply-add-by-indexed-element operation across a group of two or four consecutive vector registers. A decoded request names the group size, a register field that sets the first register of the group, an indexed source register, a 3-bit element index, one of four 32-bit select registers and a 3-bit offset. The sequencer issues one step per register in the group. Each step reads one source register, the indexed register and one accumulator row. It forwards the three operand vectors to an external multiply-add lane unit and writes that unit's result back into the same row.

The indexed operand is not spread across the whole vector. In every 128-bit segment, each 16-bit lane receives the element at the chosen index inside that segment. Accumulator rows start at the select value plus the offset, reduced modulo a stride. The stride is the number of rows divided by the group size, and the row grows by that stride on each step. The lane unit has a fixed latency. A step's read is never issued before the write of the previous step has landed, so the read-modify-write of each row keeps step order.

Top module: `idx_fma_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken on a rising clock edge with `req_valid` and `req_ready` both high. Request inputs seen while busy have no effect on the running operation.
- R2: A pair (`req_quad`=0) runs 2 steps and a quad (`req_quad`=1) runs 4. Each step gives exactly one `rd_en` cycle, and steps run in ascending order.
- R3: On step r, `rd_src_reg` = base + r. For a pair the base is `req_zn`×2. For a quad it is `req_zn[2:0]`×4.
- R4: `rd_idx_reg` equals the accepted `req_zm` on every step.
- R5: The select value is bits [32·`req_sel` +: 32] of `sel_file`, taken as unsigned. The first row is (select value + `req_off`) mod stride, where stride = (VLEN/8)/group size.
- R6: Each later step's row is the previous row plus the stride.
- R7: The index is {`req_idx_hi`,`req_idx_lo`}. Lane e selects element 8·⌊e/8⌋ + index. That lane number sits in `bcast_sel` bits [e·LIDX_W +: LIDX_W], and lane e of `fma_b` is that element of `idx_data`.
- R8: In an `rd_en` cycle `fma_valid` is high, `fma_a` equals `src_data` and `fma_c` equals `acc_rd_data`.
- R9: Exactly FMA_LAT cycles after a step's `rd_en`, `wr_en` is high for one cycle, with `wr_row` equal to that step's read row and `wr_data` equal to `fma_res` in all lanes.
- R10: `rd_en` and `wr_en` are never high together. Each step after the first reads in the cycle that follows the previous write.
- R11: `busy` rises in the cycle after acceptance and holds until the final write. `done` pulses for one cycle together with the final write, and the block is idle in the next cycle.
- R12: During and right after reset the block is idle: `req_ready`=1 and `busy`, `done`, `rd_en`, `wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_quad | input | 1 | 1 = four-register group, 0 = pair |
| req_zn | input | 4 | Register field for the first source group |
| req_zm | input | 4 | Indexed source register, 0..15 |
| req_idx_hi | input | 1 | Element index, high bit |
| req_idx_lo | input | 2 | Element index, low bits |
| req_sel | input | 2 | Select register choice |
| req_off | input | 3 | Row offset, 0..7 |
| sel_file | input | 128 | Four 32-bit select register values |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final write of the operation |
| rd_en | output | 1 | Step read strobe |
| rd_src_reg | output | 5 | First-source register for this step |
| rd_idx_reg | output | 4 | Indexed source register |
| rd_acc_row | output | $clog2(VLEN/8) | Accumulator row to read |
| src_data | input | VLEN | First-source register contents |
| idx_data | input | VLEN | Indexed register contents |
| acc_rd_data | input | VLEN | Accumulator row contents |
| bcast_sel | output | (VLEN/16)·LIDX_W | Per-lane source lane of the indexed operand |
| fma_valid | output | 1 | Operands valid for the lane unit |
| fma_a | output | VLEN | Multiplicand lanes |
| fma_b | output | VLEN | Broadcast multiplier lanes |
| fma_c | output | VLEN | Addend lanes |
| fma_res | input | VLEN | Lane unit result, FMA_LAT cycles after operands |
| wr_en | output | 1 | Row write strobe |
| wr_row | output | $clog2(VLEN/8) | Row written |
| wr_data | output | VLEN | Row write data |

## Verification
On every cycle, the checker enforces the handshake and busy relation, and the exclusion of reads and writes. It also checks the read-to-write latency, that each write goes to the row just read, that source registers ascend by one, that rows grow within a single operation, and that a new read follows straight after the previous write. Only the bench's sweeps can show the actual numbers. These cover the base register arithmetic for pairs and quads, and the modulo row placement, including select values that wrap near 2^32. They also cover the per-segment broadcast pattern for all eight indices, and the written data against a lane model fed from the bench's own register and row arrays.

// File: rtl/idx_fma_seq_pkg.sv
package idx_fma_seq_pkg;
   localparam int SEG_W     = 128;
   localparam int ELEM_W    = 16;
   localparam int SEG_LANES = SEG_W / ELEM_W;
   localparam int SEL_W     = 32;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_WRITE
   } seq_state_e;
endpackage

// File: rtl/idx_fma_seq_ctrl.sv
module idx_fma_seq_ctrl
   import idx_fma_seq_pkg::*;
#(
   parameter int FMA_LAT = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_quad,
   output logic       req_ready,
   output logic       accept,
   output logic       issue,
   output logic       write,
   output logic       advance,
   output logic       busy,
   output logic       done,
   output logic [1:0] step
);
   localparam int                CNT_W  = $clog2(FMA_LAT + 1);
   localparam logic [CNT_W-1:0]  LAT_M1 = CNT_W'(FMA_LAT - 1);

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [1:0]       step_q;
   logic             quad_q;
   logic             last;

   assign last      = (step_q == (quad_q ? 2'd3 : 2'd1));
   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign issue     = (state_q == ST_ISSUE);
   assign write     = (state_q == ST_WRITE);
   assign busy      = (state_q != ST_IDLE);
   assign done      = write && last;
   assign advance   = write && !last;
   assign step      = step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         step_q  <= '0;
         quad_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_ISSUE;
                  step_q  <= '0;
                  quad_q  <= req_quad;
               end
            end
            ST_ISSUE: begin
               cnt_q   <= LAT_M1;
               state_q <= (FMA_LAT == 1) ? ST_WRITE : ST_WAIT;
            end
            ST_WAIT: begin
               cnt_q <= cnt_q - CNT_W'(1);
               if (cnt_q == CNT_W'(1)) state_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (last) begin
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_ISSUE;
                  step_q  <= step_q + 2'd1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/idx_fma_seq_rows.sv
module idx_fma_seq_rows
   import idx_fma_seq_pkg::*;
#(
   parameter int ROWS = 32,
   parameter int RW   = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             advance,
   input  logic             req_quad,
   input  logic [SEL_W-1:0] sel_val,
   input  logic [2:0]       off,
   output logic [RW-1:0]    row
);
   localparam int STRIDE_PAIR = ROWS / 2;
   localparam int STRIDE_QUAD = ROWS / 4;

   logic [SEL_W:0]  sum;
   logic [SEL_W:0]  mod_pair;
   logic [SEL_W:0]  mod_quad;
   logic [RW-1:0]   first_row;
   logic [RW-1:0]   stride_q;
   logic [RW-1:0]   row_q;

   assign sum       = {1'b0, sel_val} + (SEL_W + 1)'(off);
   assign mod_pair  = sum % (SEL_W + 1)'(STRIDE_PAIR);
   assign mod_quad  = sum % (SEL_W + 1)'(STRIDE_QUAD);
   assign first_row = req_quad ? RW'(mod_quad) : RW'(mod_pair);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q    <= '0;
         stride_q <= '0;
      end else if (accept) begin
         row_q    <= first_row;
         stride_q <= req_quad ? RW'(STRIDE_QUAD) : RW'(STRIDE_PAIR);
      end else if (advance) begin
         row_q    <= row_q + stride_q;
      end
   end

   assign row = row_q;
endmodule

// File: rtl/idx_fma_seq_bcast.sv
module idx_fma_seq_bcast
   import idx_fma_seq_pkg::*;
#(
   parameter int VLEN   = 256,
   parameter int LANES  = VLEN / ELEM_W,
   parameter int LIDX_W = $clog2(LANES)
) (
   input  logic [2:0]              idx,
   input  logic [VLEN-1:0]         idx_data,
   output logic [LANES*LIDX_W-1:0] sel_flat,
   output logic [VLEN-1:0]         bdata
);
   for (genvar e = 0; e < LANES; e++) begin : g_lane
      localparam int SEG_BASE = (e / SEG_LANES) * SEG_LANES;
      logic [LIDX_W-1:0] pick;
      assign pick = LIDX_W'(SEG_BASE) + LIDX_W'(idx);
      assign sel_flat[e*LIDX_W +: LIDX_W] = pick;
      assign bdata[e*ELEM_W +: ELEM_W]    = idx_data[32'(pick) * ELEM_W +: ELEM_W];
   end
endmodule

// File: rtl/idx_fma_seq.sv
module idx_fma_seq
   import idx_fma_seq_pkg::*;
#(
   parameter int VLEN    = 256,
   parameter int FMA_LAT = 3,
   localparam int ROWS   = VLEN / 8,
   localparam int RW     = $clog2(ROWS),
   localparam int LANES  = VLEN / ELEM_W,
   localparam int LIDX_W = $clog2(LANES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_quad,
   input  logic [3:0]              req_zn,
   input  logic [3:0]              req_zm,
   input  logic                    req_idx_hi,
   input  logic [1:0]              req_idx_lo,
   input  logic [1:0]              req_sel,
   input  logic [2:0]              req_off,
   input  logic [4*SEL_W-1:0]      sel_file,
   output logic                    busy,
   output logic                    done,
   output logic                    rd_en,
   output logic [4:0]              rd_src_reg,
   output logic [3:0]              rd_idx_reg,
   output logic [RW-1:0]           rd_acc_row,
   input  logic [VLEN-1:0]         src_data,
   input  logic [VLEN-1:0]         idx_data,
   input  logic [VLEN-1:0]         acc_rd_data,
   output logic [LANES*LIDX_W-1:0] bcast_sel,
   output logic                    fma_valid,
   output logic [VLEN-1:0]         fma_a,
   output logic [VLEN-1:0]         fma_b,
   output logic [VLEN-1:0]         fma_c,
   input  logic [VLEN-1:0]         fma_res,
   output logic                    wr_en,
   output logic [RW-1:0]           wr_row,
   output logic [VLEN-1:0]         wr_data
);
   if (VLEN % SEG_W != 0 || VLEN < SEG_W) begin : g_bad_vlen
      $error("idx_fma_seq: VLEN must be a positive multiple of 128");
   end
   if (FMA_LAT < 1) begin : g_bad_lat
      $error("idx_fma_seq: FMA_LAT must be at least 1");
   end

   logic        accept, issue, write, advance;
   logic [1:0]  step;
   logic [4:0]  base_q;
   logic [3:0]  zm_q;
   logic [2:0]  idx_q;
   logic [4:0]  base_next;
   logic [RW-1:0] row;

   assign base_next = req_quad ? {req_zn[2:0], 2'b00} : {req_zn, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         zm_q   <= '0;
         idx_q  <= '0;
      end else if (accept) begin
         base_q <= base_next;
         zm_q   <= req_zm;
         idx_q  <= {req_idx_hi, req_idx_lo};
      end
   end

   idx_fma_seq_ctrl #(.FMA_LAT(FMA_LAT)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_quad  (req_quad),
      .req_ready (req_ready),
      .accept    (accept),
      .issue     (issue),
      .write     (write),
      .advance   (advance),
      .busy      (busy),
      .done      (done),
      .step      (step)
   );

   idx_fma_seq_rows #(.ROWS(ROWS), .RW(RW)) u_rows (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .advance  (advance),
      .req_quad (req_quad),
      .sel_val  (sel_file[{req_sel, 5'b0} +: SEL_W]),
      .off      (req_off),
      .row      (row)
   );

   idx_fma_seq_bcast #(.VLEN(VLEN), .LANES(LANES), .LIDX_W(LIDX_W)) u_bcast (
      .idx      (idx_q),
      .idx_data (idx_data),
      .sel_flat (bcast_sel),
      .bdata    (fma_b)
   );

   assign rd_en      = issue;
   assign rd_src_reg = base_q + {3'b000, step};
   assign rd_idx_reg = zm_q;
   assign rd_acc_row = row;
   assign fma_valid  = issue;
   assign fma_a      = src_data;
   assign fma_c      = acc_rd_data;
   assign wr_en      = write;
   assign wr_row     = row;
   assign wr_data    = fma_res;
endmodule

// File: rtl/idx_fma_seq_chk.sv
module idx_fma_seq_chk #(
   parameter int VLEN    = 256,
   parameter int FMA_LAT = 3,
   localparam int ROWS   = VLEN / 8,
   localparam int RW     = $clog2(ROWS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          busy,
   input logic          done,
   input logic          rd_en,
   input logic [4:0]    rd_src_reg,
   input logic [RW-1:0] rd_acc_row,
   input logic          wr_en,
   input logic [RW-1:0] wr_row
);
   localparam int CW = $clog2(FMA_LAT + 2) + 1;

   logic [CW-1:0] since_rd;
   logic          have_prev;
   logic [4:0]    prev_src;
   logic [RW-1:0] prev_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rd  <= '0;
         have_prev <= 1'b0;
         prev_src  <= '0;
         prev_row  <= '0;
      end else begin
         if (rd_en) since_rd <= CW'(1);
         else if (since_rd != '0 && since_rd < CW'(FMA_LAT + 1)) since_rd <= since_rd + CW'(1);
         if (rd_en) begin
            prev_src  <= rd_src_reg;
            prev_row  <= rd_acc_row;
            have_prev <= 1'b1;
         end else if (done) begin
            have_prev <= 1'b0;
         end
      end
   end

   a_r1_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready != busy);
   a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (busy && rd_en));
   a_r3_src_ascends: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && have_prev) |-> (rd_src_reg == prev_src + 5'd1));
   a_r5_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (32'(rd_acc_row) < ROWS));
   a_r6_row_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && have_prev) |-> (rd_acc_row > prev_row));
   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (since_rd == CW'(FMA_LAT)));
   a_r9_same_row: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_row == prev_row));
   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_en, wr_en}));
   a_r10_read_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && have_prev) |-> $past(wr_en));
   a_r11_done_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> wr_en);
   a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

bind idx_fma_seq idx_fma_seq_chk #(.VLEN(VLEN), .FMA_LAT(FMA_LAT)) u_chk (.*);

// File: tb/idx_fma_seq_tb.sv
module idx_fma_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int VLEN    = 256;
   localparam int FMA_LAT = 3;
   localparam int ROWS    = VLEN / 8;
   localparam int RW      = $clog2(ROWS);
   localparam int LANES   = VLEN / 16;
   localparam int LIDX_W  = $clog2(LANES);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_quad = 1'b0, req_idx_hi = 1'b0;
   logic [3:0] req_zn = '0, req_zm = '0;
   logic [1:0] req_idx_lo = '0, req_sel = '0;
   logic [2:0] req_off = '0;
   logic [127:0] sel_file = '0;
   logic req_ready, busy, done, rd_en, fma_valid, wr_en;
   logic [4:0] rd_src_reg;
   logic [3:0] rd_idx_reg;
   logic [RW-1:0] rd_acc_row, wr_row;
   logic [VLEN-1:0] src_data, idx_data, acc_rd_data, fma_a, fma_b, fma_c, fma_res, wr_data;
   logic [LANES*LIDX_W-1:0] bcast_sel;

   logic [VLEN-1:0] vreg [32];
   logic [VLEN-1:0] acc  [ROWS];
   logic [VLEN-1:0] pipe [FMA_LAT];

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   idx_fma_seq #(.VLEN(VLEN), .FMA_LAT(FMA_LAT)) u_dut (.*);

   function automatic logic [VLEN-1:0] lane_fma(logic [VLEN-1:0] a, logic [VLEN-1:0] b, logic [VLEN-1:0] c);
      logic [VLEN-1:0] r;
      for (int e = 0; e < LANES; e++) r[e*16 +: 16] = a[e*16 +: 16] * b[e*16 +: 16] + c[e*16 +: 16];
      return r;
   endfunction

   always_comb begin
      src_data    = vreg[rd_src_reg];
      idx_data    = vreg[{1'b0, rd_idx_reg}];
      acc_rd_data = acc[rd_acc_row];
      fma_res     = pipe[FMA_LAT-1];
   end

   always_ff @(posedge clk) begin
      pipe[0] <= lane_fma(fma_a, fma_b, fma_c);
      for (int k = 1; k < FMA_LAT; k++) pipe[k] <= pipe[k-1];
      if (wr_en) acc[wr_row] <= wr_data;
   end

   task automatic check(bit ok, string req, string what, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(bit quad, int zn, int zm, int idx, int sel, int off, logic [31:0] selval);
      int nreg, base, stride, first, row;
      longint unsigned s;
      logic [VLEN-1:0] exp_b, exp_w;
      logic [LANES*LIDX_W-1:0] exp_sel;
      nreg   = quad ? 4 : 2;
      base   = quad ? (zn % 8) * 4 : zn * 2;
      stride = ROWS / nreg;
      s      = {32'b0, selval};
      s      = s + longint'(off);
      first  = int'(s % longint'(stride));
      @(negedge clk);
      sel_file[sel*32 +: 32] = selval;
      req_quad = quad; req_zn = 4'(zn); req_zm = 4'(zm);
      req_idx_hi = idx[2]; req_idx_lo = idx[1:0];
      req_sel = 2'(sel); req_off = 3'(off); req_valid = 1'b1;
      check(req_ready == 1'b1, "R1", "ready when idle", VLEN'(req_ready), VLEN'(1));
      @(negedge clk);
      // R1: changed request while busy must not alter the running operation
      req_zm = 4'(zm ^ 1); req_off = 3'(off + 1); req_zn = 4'(zn ^ 3);
      sel_file[sel*32 +: 32] = selval + 32'd5;
      check(req_ready == 1'b0, "R1", "ready low while busy", VLEN'(req_ready), VLEN'(0));
      for (int r = 0; r < nreg; r++) begin
         row = first + r * stride;
         check(rd_en && busy && fma_valid, "R2", "step read strobe", VLEN'({rd_en, busy, fma_valid}), VLEN'(3'b111));
         check(rd_src_reg == 5'(base + r), "R3", "source register", VLEN'(rd_src_reg), VLEN'(base + r));
         check(rd_idx_reg == 4'(zm), "R4", "indexed register", VLEN'(rd_idx_reg), VLEN'(zm));
         check(rd_acc_row == RW'(row), r == 0 ? "R5" : "R6", "accumulator row", VLEN'(rd_acc_row), VLEN'(row));
         for (int e = 0; e < LANES; e++) begin
            int lp;
            lp = (e / 8) * 8 + idx;
            exp_sel[e*LIDX_W +: LIDX_W] = LIDX_W'(lp);
            exp_b[e*16 +: 16] = vreg[zm][lp*16 +: 16];
            exp_w[e*16 +: 16] = vreg[base + r][e*16 +: 16] * vreg[zm][lp*16 +: 16] + acc[row][e*16 +: 16];
         end
         check(bcast_sel == exp_sel, "R7", "lane selection", VLEN'(bcast_sel), VLEN'(exp_sel));
         check(fma_b == exp_b, "R7", "broadcast lanes", fma_b, exp_b);
         check(fma_a == vreg[base + r] && fma_c == acc[row], "R8", "forwarded operands", fma_c, acc[row]);
         for (int k = 1; k < FMA_LAT; k++) begin
            @(negedge clk);
            check(!rd_en && !wr_en && busy, "R10", "quiet wait cycle", VLEN'({rd_en, wr_en, busy}), VLEN'(1));
         end
         @(negedge clk);
         check(wr_en == 1'b1, "R9", "write after latency", VLEN'(wr_en), VLEN'(1));
         check(wr_row == RW'(row), "R9", "write row", VLEN'(wr_row), VLEN'(row));
         check(wr_data == exp_w, "R9", "write data", wr_data, exp_w);
         check(done == (r == nreg - 1), "R11", "done pulse", VLEN'(done), VLEN'(r == nreg - 1));
         if (r == nreg - 1) req_valid = 1'b0;
         @(negedge clk);
      end
      check(!busy && req_ready && !rd_en && !done, "R11", "idle after final write", VLEN'({busy, req_ready, rd_en, done}), VLEN'(4'b0100));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] vals [4];
      vals[0] = 32'd0; vals[1] = 32'd5; vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h8000_0013;
      for (int i = 0; i < 32; i++)
         for (int e = 0; e < LANES; e++) vreg[i][e*16 +: 16] = 16'((i * 37 + e * 11 + 5) & 8'hFF);
      for (int i = 0; i < ROWS; i++)
         for (int e = 0; e < LANES; e++) acc[i][e*16 +: 16] = 16'(i * 101 + e * 7);
      for (int k = 0; k < FMA_LAT; k++) pipe[k] = '0;
      repeat (3) @(negedge clk);
      check(req_ready && !busy && !done && !rd_en && !wr_en, "R12", "reset state",
            VLEN'({req_ready, busy, done, rd_en, wr_en}), VLEN'(5'b10000));
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !busy && !rd_en && !wr_en, "R12", "idle after reset",
            VLEN'({req_ready, busy, rd_en, wr_en}), VLEN'(4'b1000));
      for (int q = 0; q < 2; q++)
         for (int idx = 0; idx < 8; idx++)
            for (int off = 0; off < 8; off++)
               run_op(q[0], (idx * 3 + off) % 16, (idx + off * 5) % 16, idx, off % 4, off,
                      vals[(idx + off) % 4]);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule